// File: doc/BRIEF.md
# Bus Master Command Sequencer

This block runs one transfer at a time on an asynchronous, fully handshaked shared bus. The local side hands it an address, write data, a read-or-write flag and a memory-or-I/O flag. Once the arbitration grant is present, the block does the following:

- It places the address on active-low lines. On a write it also places the data.
- It waits a computed number of local clock cycles so that the lines settle before the command.
- It asserts exactly one of four active-low command strobes.
- It holds that strobe until the slave's acknowledge arrives through a synchronizer.
- On a read, it captures the data bus on the edge where the acknowledge is first seen.
- It removes the strobe and keeps the address steady for a second computed interval.
- It then pulses `done`.

The block meets the nanosecond limits by counting cycles. The local clock period is a parameter, and the setup and hold counts are derived from it, rounded up to whole cycles. Address and data are inverted between local and bus form, because a low line on the bus means logic 1.

If a slave never answers, a timeout counter ends the cycle and raises an error flag. A parameter also selects an 8-bit variant. In that variant only the low eight data lines are ever driven or read.

Top module: `bus_cmd_seq`

## Requirements
- R1: After reset, all four strobes are high and every address line is high. No data line is enabled, `req_ready` is 1, and `done` and `timeout_err` are 0.
- R2: A request is accepted only on a clock edge where `req_ready`, `req_valid` and `grant` are all 1. While `grant` is 0, the bus stays idle and `req_ready` stays 1.
- R3: The address, and on a write the data, are driven for at least ceil(SETUP_NS*1000/CLK_PERIOD_PS) clock cycles before any strobe goes low. With the defaults this is 5 cycles.
- R4: Exactly one strobe is active per cycle, selected by {io, write}: 00 memory read (`bus_mrd_n`), 01 memory write (`bus_mwr_n`), 10 I/O read (`bus_iord_n`), 11 I/O write (`bus_iowr_n`). At most one strobe is ever low.
- R5: The bus carries inverted values. `bus_adr_n` = ~addr, `bus_dat_out_n` = ~wdata, and on a read `rd_data` = ~`bus_dat_in_n`.
- R6: The strobe stays low until the acknowledge (`bus_ack_n` low) has passed the synchronizer. Read data is captured on that same edge, however long the slave takes.
- R7: After the strobe rises, the address stays unchanged for at least ceil(HOLD_NS*1000/CLK_PERIOD_PS) cycles (5 by default). After that, `done` pulses high for exactly one cycle and the address lines return high.
- R8: `bus_dat_oe` is nonzero only during write cycles, from the address phase through the hold. It is all-zero during reads and when idle.
- R9: If no acknowledge arrives within TIMEOUT_CYC cycles of the strobe, the strobe is removed and the hold runs. `done` then pulses with `timeout_err` = 1. A cycle that is acknowledged in time, even late, ends with `timeout_err` = 0.
- R10: With BYTE_MODE = 1, data lines 15..8 are never enabled and the upper byte of `rd_data` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Transfer address (local polarity) |
| req_wdata | input | DATA_W | Write data (local polarity) |
| grant | input | 1 | Bus ownership granted by the arbiter |
| req_ready | output | 1 | Sequencer idle and able to accept |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout_err | output | 1 | Last transfer ended without acknowledge |
| rd_data | output | DATA_W | Captured read data (local polarity) |
| bus_adr_n | output | ADDR_W | Active-low address lines |
| bus_dat_out_n | output | DATA_W | Active-low data driven to the bus |
| bus_dat_oe | output | DATA_W | Per-line data drive enable |
| bus_dat_in_n | input | DATA_W | Active-low data sampled from the bus |
| bus_mrd_n | output | 1 | Memory read strobe, active low |
| bus_mwr_n | output | 1 | Memory write strobe, active low |
| bus_iord_n | output | 1 | I/O read strobe, active low |
| bus_iowr_n | output | 1 | I/O write strobe, active low |
| bus_ack_n | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
The hardest case to reach is a cycle whose acknowledge never comes, or comes very late, because every ordinary slave answers promptly. The bench's slave model takes a per-transfer acknowledge delay and a no-answer flag from the scoreboard item. One transfer leaves the strobe hanging until the timeout fires. The next answers after thirty cycles, which must still end cleanly. The same model counts the cycles the address was steady before each strobe fell and after it rose, so setup and hold are measured at the pins. An 8-bit instance shares the stimulus, so its lane restriction is checked on the same traffic.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_CMD   = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_t;

   // Strobe index is {io, write}
   typedef enum logic [1:0] {
      K_MEM_RD = 2'b00,
      K_MEM_WR = 2'b01,
      K_IO_RD  = 2'b10,
      K_IO_WR  = 2'b11
   } cmd_kind_t;

   // Whole clock cycles covering a time in ns, rounded up, never below one
   function automatic int cycles_for(input int ns, input int period_ps);
      int c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/bus_cmd_sync.sv
module bus_cmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic seen
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bus_cmd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], ~async_n};
   end

   assign seen = shreg[STAGES-1];
endmodule

// File: rtl/bus_cmd_timer.sv
module bus_cmd_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/bus_cmd_strobe.sv
module bus_cmd_strobe (
   input  logic       active,
   input  logic [1:0] kind,
   output logic [3:0] strobe_n
);
   for (genvar k = 0; k < 4; k++) begin : g_strobe
      assign strobe_n[k] = ~(active && (kind == 2'(k)));
   end
endmodule

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq
   import bus_cmd_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 16,
   parameter bit BYTE_MODE     = 1'b0,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int SETUP_NS      = 50,
   parameter int HOLD_NS       = 50,
   parameter int TIMEOUT_CYC   = 256,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              grant,
   output logic              req_ready,
   output logic              done,
   output logic              timeout_err,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_adr_n,
   output logic [DATA_W-1:0] bus_dat_out_n,
   output logic [DATA_W-1:0] bus_dat_oe,
   input  logic [DATA_W-1:0] bus_dat_in_n,
   output logic              bus_mrd_n,
   output logic              bus_mwr_n,
   output logic              bus_iord_n,
   output logic              bus_iowr_n,
   input  logic              bus_ack_n
);
   localparam int SETUP_CYC = cycles_for(SETUP_NS, CLK_PERIOD_PS);
   localparam int HOLD_CYC  = cycles_for(HOLD_NS, CLK_PERIOD_PS);
   localparam int MAX_CYC   = (TIMEOUT_CYC > SETUP_CYC) ?
                              ((TIMEOUT_CYC > HOLD_CYC) ? TIMEOUT_CYC : HOLD_CYC) :
                              ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("bus_cmd_seq: TIMEOUT_CYC must be positive");
   end
   if (BYTE_MODE && DATA_W <= 8) begin : g_bad_width
      $error("bus_cmd_seq: BYTE_MODE needs DATA_W above 8");
   end
   if (CLK_PERIOD_PS < 1) begin : g_bad_period
      $error("bus_cmd_seq: CLK_PERIOD_PS must be positive");
   end

   seq_state_t        state;
   logic              lat_write, lat_io, err_q;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata, rd_q, lane_in;
   logic              ack_seen, t_zero, t_load, start, drive_en, cmd_active;
   logic [CNT_W-1:0]  t_val;
   logic [3:0]        strobe_n;

   assign start = (state == ST_IDLE) && req_valid && grant;

   bus_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(bus_ack_n), .seen(ack_seen));

   // One down-counter serves the setup, timeout and hold intervals in turn
   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      unique case (state)
         ST_IDLE:  if (start)  begin t_load = 1'b1; t_val = CNT_W'(SETUP_CYC - 1); end
         ST_SETUP: if (t_zero) begin t_load = 1'b1; t_val = CNT_W'(TIMEOUT_CYC - 1); end
         ST_CMD:   if (ack_seen || t_zero) begin t_load = 1'b1; t_val = CNT_W'(HOLD_CYC - 1); end
         default:  ;
      endcase
   end

   bus_cmd_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_zero));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_write <= 1'b0;
         lat_io    <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         rd_q      <= '0;
         err_q     <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               lat_write <= req_write;
               lat_io    <= req_io;
               lat_addr  <= req_addr;
               lat_wdata <= req_wdata;
               err_q     <= 1'b0;
               state     <= ST_SETUP;
            end
            ST_SETUP: if (t_zero) state <= ST_CMD;
            ST_CMD: begin
               if (ack_seen) begin
                  if (!lat_write) rd_q <= lane_in;
                  state <= ST_HOLD;
               end else if (t_zero) begin
                  err_q <= 1'b1;
                  state <= ST_HOLD;
               end
            end
            ST_HOLD: if (t_zero) begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_active = (state == ST_CMD);
   assign drive_en   = lat_write && (state != ST_IDLE);

   bus_cmd_strobe u_strobe (
      .active(cmd_active), .kind({lat_io, lat_write}), .strobe_n(strobe_n));

   assign bus_mrd_n  = strobe_n[K_MEM_RD];
   assign bus_mwr_n  = strobe_n[K_MEM_WR];
   assign bus_iord_n = strobe_n[K_IO_RD];
   assign bus_iowr_n = strobe_n[K_IO_WR];

   // Data lane width variant
   if (BYTE_MODE) begin : g_narrow
      assign lane_in    = {{(DATA_W-8){1'b0}}, ~bus_dat_in_n[7:0]};
      assign bus_dat_oe = {{(DATA_W-8){1'b0}}, {8{drive_en}}};
   end else begin : g_full
      assign lane_in    = ~bus_dat_in_n;
      assign bus_dat_oe = {DATA_W{drive_en}};
   end

   assign bus_adr_n     = (state != ST_IDLE) ? ~lat_addr : '1;
   assign bus_dat_out_n = drive_en ? ~lat_wdata : '1;
   assign req_ready     = (state == ST_IDLE);
   assign rd_data       = rd_q;
   assign timeout_err   = err_q;

   // R4
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~strobe_n));
   // R3
   setup_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(~&strobe_n) |-> $stable(bus_adr_n) && $stable(bus_dat_out_n));
   // R7
   adr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(~&strobe_n) |-> $stable(bus_adr_n));
   // R8
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_mrd_n || !bus_iord_n) |-> (bus_dat_oe == '0));
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !(req_valid && grant)) |=> req_ready);
endmodule

// File: tb/bus_cmd_seq_test.sv
module bus_cmd_seq_test;

   typedef struct {
      bit          wr;
      bit          io;
      logic [15:0] addr;
      logic [15:0] wdata;
      logic [15:0] rdata;
      int          ack_dly;
      bit          no_ack;
   } item_t;

   localparam int SETUP_EXP = 5;   // ceil(50 ns / 10 ns)
   localparam int HOLD_EXP  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, grant = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        ack_n = 1'b1;
   logic [15:0] dat_in_n = '1;

   logic        req_ready, done, timeout_err, mrd_n, mwr_n, iord_n, iowr_n;
   logic [15:0] rd_data, adr_n, dout_n, oe;
   logic        b_ready, b_done, b_err, b_mrd, b_mwr, b_iord, b_iowr;
   logic [15:0] b_rd, b_adr, b_dout, b_oe;

   int errors = 0, checks = 0;
   item_t slv_q[$], mon_q[$];

   always #5 clk = ~clk;

   bus_cmd_seq #(.TIMEOUT_CYC(40)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
      .req_ready(req_ready), .done(done), .timeout_err(timeout_err),
      .rd_data(rd_data), .bus_adr_n(adr_n), .bus_dat_out_n(dout_n),
      .bus_dat_oe(oe), .bus_dat_in_n(dat_in_n), .bus_mrd_n(mrd_n),
      .bus_mwr_n(mwr_n), .bus_iord_n(iord_n), .bus_iowr_n(iowr_n),
      .bus_ack_n(ack_n));

   bus_cmd_seq #(.TIMEOUT_CYC(40), .BYTE_MODE(1'b1)) uut_b (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
      .req_ready(b_ready), .done(b_done), .timeout_err(b_err),
      .rd_data(b_rd), .bus_adr_n(b_adr), .bus_dat_out_n(b_dout),
      .bus_dat_oe(b_oe), .bus_dat_in_n(dat_in_n), .bus_mrd_n(b_mrd),
      .bus_mwr_n(b_mwr), .bus_iord_n(b_iord), .bus_iowr_n(b_iowr),
      .bus_ack_n(ack_n));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Slave model: measures setup/hold at the pins and answers each strobe
   logic [15:0] prev_adr = '1;
   int          same_cnt = 0, hold_cnt = 0, ack_cnt = 0;
   bit          cmd_prev = 1'b0, in_hold = 1'b0;
   item_t       cur;

   always @(negedge clk) begin
      logic       cmd_now;
      logic [3:0] exp_str, got_str;
      cmd_now = ~&{mrd_n, mwr_n, iord_n, iowr_n};
      if (adr_n == prev_adr) same_cnt++; else same_cnt = 0;
      prev_adr = adr_n;
      if (rst_n && cmd_now && !cmd_prev) begin
         if (slv_q.size() == 0) begin
            chk(0, "R2", "strobe without request", 1, 0);
         end else begin
            cur = slv_q.pop_front();
            chk(same_cnt >= SETUP_EXP, "R3", "address lead cycles", same_cnt, SETUP_EXP);
            exp_str = ~(4'b0001 << {cur.io, cur.wr});
            got_str = {iowr_n, iord_n, mwr_n, mrd_n};
            chk(got_str == exp_str, "R4", "strobe select", got_str, exp_str);
            chk(adr_n == ~cur.addr, "R5", "inverted address", adr_n, ~cur.addr);
            if (cur.wr) begin
               chk(oe == 16'hFFFF, "R8", "write drive enable", oe, 16'hFFFF);
               chk(dout_n == ~cur.wdata, "R5", "inverted write data", dout_n, ~cur.wdata);
               chk(b_oe == 16'h00FF, "R10", "byte mode enable", b_oe, 16'h00FF);
            end else begin
               chk(oe == 16'h0000, "R8", "read drive enable", oe, 0);
               chk(b_oe == 16'h0000, "R8", "byte read enable", b_oe, 0);
            end
            ack_cnt = cur.ack_dly;
         end
      end
      if (cmd_now && !cur.no_ack) begin
         if (ack_cnt == 0) begin
            ack_n = 1'b0;
            dat_in_n = ~cur.rdata;
         end else ack_cnt--;
      end
      if (!cmd_now && cmd_prev) begin
         ack_n = 1'b1;
         dat_in_n = '1;
         in_hold = 1'b1;
         hold_cnt = (adr_n == ~cur.addr) ? 1 : 0;
      end else if (in_hold && !done) begin
         if (adr_n == ~cur.addr) hold_cnt++;
      end
      if (in_hold && done) begin
         chk(hold_cnt >= HOLD_EXP, "R7", "address hold cycles", hold_cnt, HOLD_EXP);
         chk(adr_n == 16'hFFFF, "R7", "address released with done", adr_n, 16'hFFFF);
         in_hold = 1'b0;
      end
      cmd_prev = cmd_now;
   end

   // Monitor: pops the expected result at each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         item_t e;
         if (mon_q.size() == 0) begin
            chk(0, "R7", "done without request", 1, 0);
         end else begin
            e = mon_q.pop_front();
            chk(timeout_err == e.no_ack, "R9", "timeout flag", timeout_err, e.no_ack);
            if (!e.wr && !e.no_ack) begin
               chk(rd_data == e.rdata, "R6", "captured read data", rd_data, e.rdata);
               chk(b_rd == {8'h00, e.rdata[7:0]}, "R10", "byte mode read", b_rd,
                   {8'h00, e.rdata[7:0]});
            end
            chk(b_done == 1'b1, "R10", "byte instance done", b_done, 1);
         end
      end
   end

   task automatic run_item(input item_t it, input int grant_wait);
      int n;
      slv_q.push_back(it);
      mon_q.push_back(it);
      @(negedge clk);
      req_write = it.wr; req_io = it.io; req_addr = it.addr; req_wdata = it.wdata;
      req_valid = 1'b1;
      grant = (grant_wait == 0);
      for (int i = 0; i < grant_wait; i++) begin
         @(negedge clk);
         chk(adr_n == 16'hFFFF && oe == 0 && mrd_n && mwr_n && iord_n && iowr_n,
             "R2", "bus idle without grant", {adr_n, oe}, {16'hFFFF, 16'h0});
         chk(req_ready == 1'b1, "R2", "ready while waiting", req_ready, 1);
      end
      grant = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(adr_n == 16'hFFFF, "R1", "address idle", adr_n, 16'hFFFF);
      chk({mrd_n, mwr_n, iord_n, iowr_n} == 4'hF, "R1", "strobes idle",
          {mrd_n, mwr_n, iord_n, iowr_n}, 4'hF);
      chk(oe == 0 && req_ready && !done && !timeout_err, "R1", "control idle",
          {oe, req_ready, done, timeout_err}, {16'h0, 3'b100});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_item('{wr:1, io:0, addr:16'h1234, wdata:16'hA5C3, rdata:0, ack_dly:0, no_ack:0}, 0);
      run_item('{wr:0, io:0, addr:16'h1234, wdata:0, rdata:16'h5A3C, ack_dly:0, no_ack:0}, 0);
      run_item('{wr:1, io:1, addr:16'h00F1, wdata:16'h0F0F, rdata:0, ack_dly:3, no_ack:0}, 0);
      run_item('{wr:0, io:1, addr:16'h0080, wdata:0, rdata:16'h8001, ack_dly:7, no_ack:0}, 0);
      // R9 no acknowledge at all
      run_item('{wr:0, io:0, addr:16'h4000, wdata:0, rdata:16'h1111, ack_dly:0, no_ack:1}, 0);
      // R6 R9 late but in time
      run_item('{wr:0, io:0, addr:16'hFFFF, wdata:0, rdata:16'hFFFF, ack_dly:30, no_ack:0}, 0);
      // R2 delayed grant
      run_item('{wr:0, io:1, addr:16'h2468, wdata:0, rdata:16'hC396, ack_dly:2, no_ack:0}, 6);
      run_item('{wr:1, io:0, addr:16'h7001, wdata:16'hFFFE, rdata:0, ack_dly:1, no_ack:0}, 0);

      chk(mon_q.size() == 0 && slv_q.size() == 0, "R7", "all transfers completed",
          mon_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule